// File: doc/BRIEF.md
# SPI Flash Hardware-Sequenced Controller

This block runs complete SPI NOR flash operations without software handling individual opcodes. Software loads a flash address, optionally fills a 64-byte data buffer, and then writes the control register. That write carries an encoded cycle type, a byte count and a go bit. The controller then builds the whole command sequence on a single-lane SPI master: the opcode, an optional 3-byte address, data bytes in either direction and, for every modifying cycle, a preceding write-enable frame. When the cycle finishes, the controller raises a done flag.

Erase opcodes are not fixed. They are read from an erase-opcode register, and a zero entry there means hardware erase is not available. A read or write that would run past a 4 KiB page is refused before any SPI traffic is produced. A sticky lock bit freezes the erase-opcode register until the next reset.

Top module: `spi_flash_seq`

## Requirements
- R1: After reset, the control register (offset 0x04) and the erase-opcode register (offset 0x60) read 0, `spi_cs_n` is high and `spi_sck` is low. The flash address sits at offset 0x08, bits 23:0. Buffer word w sits at offset 0x10+4w, and buffer byte k occupies word k/4, bits 8*(k%4)+7 down to 8*(k%4).
- R2: Cycle type 0 (bits 20:17) is a read. It produces one frame: opcode 0x03, then the address most significant byte first, then N bytes captured into the buffer. N is the count field (bits 29:24) plus one. The bus is SPI mode 0, MSB first: MOSI changes while SCK is low, MISO is sampled on the rising edge, and SCK stays low while CS is high.
- R3: Cycle type 2 is a write. It sends a frame holding only 0x06, then raises CS for at least one clock, then sends a frame of 0x02, the 3 address bytes and N buffer bytes.
- R4: Cycle types 3 and 4 send a 0x06 frame, then a frame of an opcode plus the 3 address bytes. The opcode comes from erase-opcode register bits 15:8 for type 3 and bits 23:16 for type 4. If the selected opcode is zero, the cycle produces no SPI traffic and sets done (bit 0) and access error (bit 2).
- R5: Cycle type 6 sends 0x9F and type 8 sends 0x05; each then captures N bytes into the buffer. Cycle type 7 sends a 0x06 frame, then a frame of 0x01 followed by N buffer bytes.
- R6: A type 0 or type 2 cycle is refused when address bits 11:0 plus N exceeds 4096. A refused cycle produces no SPI traffic and sets done and cycle error (bit 1). A transfer that ends exactly on the boundary runs normally.
- R7: Any cycle type other than 0, 2, 3, 4, 6, 7 or 8 produces no SPI traffic and sets done and cycle error.
- R8: Writing 1 to bit 16 starts a cycle. Busy (bit 5) reads 1 from the clock after that write until the cycle ends. Done is set when the cycle ends, and bit 16 reads 0.
- R9: Done, cycle error and access error each clear when written with 1, either on their own or together with go. When a flag is cleared and set in the same clock, the set wins.
- R10: While busy, a go write is ignored: it neither starts a cycle nor changes the cycle-type field. Buffer writes made while busy are also ignored.
- R11: Writing 1 to bit 15 sets the lock bit. The lock bit stays set until reset. While it is set, writes to the erase-opcode register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock, half the system clock rate |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
Two things can fall in the same clock: the write-1-to-clear of the status flags and their setting by a refused cycle. Software always writes 1s to the flags together with go, so the refusal lands on exactly that edge. The bench first leaves done and cycle error set, then issues a go with an unsupported cycle type and all three clear bits high. It reads the flags at the next falling clock edge and expects both to still be set. A behavioural flash model on the bench checks every frame byte against a queue of expected frames. A frame that arrives when nothing is expected is a failure, which makes a refused cycle that leaks traffic visible.

// File: rtl/spi_flash_seq.sv
`timescale 1ns/1ps
module spi_flash_seq #(
  parameter int BUF_WORDS = 16,
  parameter int GAP_CLKS  = 2,
  parameter int AW        = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_we,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          spi_cs_n,
  output logic          spi_sck,
  output logic          spi_mosi,
  input  logic          spi_miso
);

  localparam int BUF_BYTES = BUF_WORDS * 4;
  localparam int BW  = $clog2(BUF_BYTES);
  localparam int WI  = $clog2(BUF_WORDS);
  localparam int GCW = $clog2(GAP_CLKS + 1);
  localparam logic [AW-1:0] OFS_CTRL  = AW'(8'h04);
  localparam logic [AW-1:0] OFS_ADDR  = AW'(8'h08);
  localparam logic [AW-1:0] OFS_BUF   = AW'(8'h10);
  localparam logic [AW-1:0] OFS_ERASE = AW'(8'h60);
  localparam logic [AW-1:0] BUF_END   = AW'(16 + BUF_BYTES);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_GAP} st_t;
  st_t st;

  logic          done_q, cerr_q, aerr_q, lock_q;
  logic [3:0]    cyc_q;
  logic [BW-1:0] cnt_q;
  logic [23:0]   faddr_q;
  logic [31:0]   erase_q;
  logic [31:0]   buf_q [BUF_WORDS];

  logic [31:0]   hdr_sr, main_hdr;
  logic [5:0]    hdr_left, main_hbits;
  logic [BW:0]   frame_n, main_n;
  logic [BW-1:0] byte_i;
  logic [2:0]    bit_i;
  logic          rx_q, wren_pend, cs_q, sck_q;
  logic [GCW-1:0] gap_cnt;
  logic [6:0]    rx_sr;

  wire busy    = (st != S_IDLE);
  wire wr_ctrl = reg_we && (reg_addr == OFS_CTRL);
  wire go      = wr_ctrl && reg_wdata[16] && !busy;
  wire [3:0]    w_cyc = reg_wdata[20:17];
  wire [BW-1:0] w_cnt = reg_wdata[24 +: BW];
  wire [BW:0]   w_len = {1'b0, w_cnt} + 1'b1;
  wire crosses = (13'({1'b0, faddr_q[11:0]}) + 13'(w_len)) > 13'd4096;

  logic [7:0]  d_op;
  logic [5:0]  d_hb;
  logic [BW:0] d_n;
  logic        d_rx, d_wren, d_ok;

  always_comb begin
    d_op = 8'h00; d_hb = 6'd8; d_n = '0; d_rx = 1'b0; d_wren = 1'b0; d_ok = 1'b1;
    case (w_cyc)
      4'd0: begin d_op = 8'h03; d_hb = 6'd32; d_n = w_len; d_rx = 1'b1; d_ok = !crosses; end
      4'd2: begin d_op = 8'h02; d_hb = 6'd32; d_n = w_len; d_wren = 1'b1; d_ok = !crosses; end
      4'd3: begin d_op = erase_q[15:8];  d_hb = 6'd32; d_wren = 1'b1; end
      4'd4: begin d_op = erase_q[23:16]; d_hb = 6'd32; d_wren = 1'b1; end
      4'd6: begin d_op = 8'h9F; d_n = w_len; d_rx = 1'b1; end
      4'd7: begin d_op = 8'h01; d_n = w_len; d_wren = 1'b1; end
      4'd8: begin d_op = 8'h05; d_n = w_len; d_rx = 1'b1; end
      default: d_ok = 1'b0;
    endcase
  end

  wire no_op  = (w_cyc == 4'd3 || w_cyc == 4'd4) && (d_op == 8'h00);
  wire launch = go && d_ok && !no_op;
  wire ref_c  = go && !d_ok;
  wire ref_a  = go && d_ok && no_op;

  wire        in_hdr   = (hdr_left != 6'd0);
  wire [31:0] cur_word = buf_q[byte_i[BW-1:2]];
  wire [7:0]  tx_byte  = cur_word[8*byte_i[1:0] +: 8];
  wire [7:0]  rx_new   = {rx_sr, spi_miso};
  wire last_bit = in_hdr ? (hdr_left == 6'd1 && frame_n == '0)
                         : (bit_i == 3'd7 && {1'b0, byte_i} == frame_n - 1'b1);
  wire fin_main = (st == S_SHIFT) && sck_q && last_bit && !wren_pend;
  wire rx_store = (st == S_SHIFT) && !sck_q && !in_hdr && rx_q && bit_i == 3'd7;

  assign spi_cs_n = cs_q;
  assign spi_sck  = sck_q;
  assign spi_mosi = !cs_q && (in_hdr ? hdr_sr[31] : (!rx_q && tx_byte[3'd7 - bit_i]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0; cerr_q <= 1'b0; aerr_q <= 1'b0; lock_q <= 1'b0;
      cyc_q <= '0; cnt_q <= '0; faddr_q <= '0; erase_q <= '0;
    end else begin
      if (wr_ctrl) begin
        if (reg_wdata[0])  done_q <= 1'b0;
        if (reg_wdata[1])  cerr_q <= 1'b0;
        if (reg_wdata[2])  aerr_q <= 1'b0;
        if (reg_wdata[15]) lock_q <= 1'b1;
        if (!busy) begin cyc_q <= w_cyc; cnt_q <= w_cnt; end
      end
      if (fin_main || ref_c || ref_a) done_q <= 1'b1;
      if (ref_c) cerr_q <= 1'b1;
      if (ref_a) aerr_q <= 1'b1;
      if (reg_we && reg_addr == OFS_ADDR && !busy) faddr_q <= reg_wdata[23:0];
      if (reg_we && reg_addr == OFS_ERASE && !lock_q) erase_q <= reg_wdata;
    end
  end

  wire          in_buf = (reg_addr >= OFS_BUF) && (reg_addr < BUF_END);
  wire [AW-1:0] boff   = reg_addr - OFS_BUF;
  wire [WI-1:0] widx   = boff[WI+1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BUF_WORDS; i++) buf_q[i] <= '0;
    end else begin
      if (reg_we && in_buf && !busy) buf_q[widx] <= reg_wdata;
      if (rx_store) buf_q[byte_i[BW-1:2]][8*byte_i[1:0] +: 8] <= rx_new;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cs_q <= 1'b1; sck_q <= 1'b0;
      hdr_sr <= '0; hdr_left <= '0; main_hdr <= '0; main_hbits <= '0;
      main_n <= '0; frame_n <= '0; byte_i <= '0; bit_i <= '0;
      rx_q <= 1'b0; wren_pend <= 1'b0; gap_cnt <= '0; rx_sr <= '0;
    end else begin
      case (st)
        S_IDLE: if (launch) begin
          main_hdr <= {d_op, faddr_q}; main_hbits <= d_hb; main_n <= d_n;
          rx_q <= d_rx; wren_pend <= d_wren; byte_i <= '0; bit_i <= '0;
          cs_q <= 1'b0; st <= S_SHIFT;
          if (d_wren) begin
            hdr_sr <= {8'h06, 24'h0}; hdr_left <= 6'd8; frame_n <= '0;
          end else begin
            hdr_sr <= {d_op, faddr_q}; hdr_left <= d_hb; frame_n <= d_n;
          end
        end
        S_SHIFT: if (!sck_q) begin
          sck_q <= 1'b1;
          if (!in_hdr) rx_sr <= rx_new[6:0];
        end else begin
          sck_q <= 1'b0;
          if (last_bit) begin
            cs_q <= 1'b1;
            if (wren_pend) begin
              wren_pend <= 1'b0; gap_cnt <= GCW'(GAP_CLKS); st <= S_GAP;
            end else st <= S_IDLE;
          end else if (in_hdr) begin
            hdr_sr <= hdr_sr << 1; hdr_left <= hdr_left - 1'b1;
          end else begin
            bit_i <= bit_i + 1'b1;
            if (bit_i == 3'd7) byte_i <= byte_i + 1'b1;
          end
        end
        S_GAP: if (gap_cnt <= GCW'(1)) begin
          cs_q <= 1'b0; hdr_sr <= main_hdr; hdr_left <= main_hbits;
          frame_n <= main_n; byte_i <= '0; bit_i <= '0; st <= S_SHIFT;
        end else gap_cnt <= gap_cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == OFS_CTRL)
      reg_rdata = {2'b0, 6'(cnt_q), 3'b0, cyc_q, 1'b0, lock_q, 9'b0, busy, 2'b0, aerr_q, cerr_q, done_q};
    else if (reg_addr == OFS_ADDR)  reg_rdata = {8'h00, faddr_q};
    else if (reg_addr == OFS_ERASE) reg_rdata = erase_q;
    else if (in_buf)                reg_rdata = buf_q[widx];
  end

  assert_sck_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);
  assert_cs_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> busy);
  assert_refuse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (go && w_cyc == 4'd0 && crosses) |=> (cerr_q && done_q && !busy && spi_cs_n));
  assert_busy_go_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_ctrl) |=> $stable(cyc_q));
  assert_lock_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  assert_erase_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && reg_we && reg_addr == OFS_ERASE) |=> $stable(erase_q));

endmodule

// File: tb/sim_spi_flash_seq.sv
`timescale 1ns/1ps
module sim_spi_flash_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] reg_addr = '0;
  logic reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic spi_cs_n, spi_sck, spi_mosi;
  logic spi_miso = 1'b0;

  localparam logic [7:0] CTRL = 8'h04, FADR = 8'h08, BUF0 = 8'h10, ERS = 8'h60;

  int checks = 0, fails = 0;
  bit finished = 0;
  string cur_tag = "R1";
  logic [7:0] exp_bytes[$];
  int exp_len[$];
  string exp_tag[$];
  logic [7:0] stage[$];

  always #2.5 clk = ~clk;

  spi_flash_seq u0 (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_cs_n(spi_cs_n),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] fdat(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  // behavioural flash: collects MOSI bytes per frame, answers reads on MISO
  logic [7:0] sr = '0;
  int nb = 0;
  logic [7:0] cur[$];
  always @(negedge spi_cs_n) begin nb = 0; cur.delete(); end
  always @(posedge spi_sck) if (!spi_cs_n) begin
    sr = {sr[6:0], spi_mosi};
    nb++;
    if (nb % 8 == 0) cur.push_back(sr);
  end
  always @(negedge spi_sck) if (!spi_cs_n && cur.size() > 0) begin
    int h, k;
    logic [7:0] b;
    h = (cur[0] == 8'h03) ? 32 : 8;
    if (nb >= h) begin
      k = (nb - h) / 8;
      case (cur[0])
        8'h03: b = fdat({cur[1], cur[2], cur[3]} + 24'(k));
        8'h9F: b = 8'hC0 + 8'(k);
        8'h05: b = 8'h5A ^ 8'(k);
        default: b = 8'h00;
      endcase
      spi_miso = b[7 - ((nb - h) % 8)];
    end
  end
  always @(posedge spi_cs_n) if (rst_n) begin
    int L;
    string t;
    bit ok;
    logic [7:0] e, ma, me;
    if (exp_len.size() == 0) chk(0, cur_tag, "unexpected SPI frame, length", cur.size(), 0);
    else begin
      L = exp_len.pop_front(); t = exp_tag.pop_front();
      ok = (cur.size() == L); ma = 8'(cur.size()); me = 8'(L);
      for (int i = 0; i < L; i++) begin
        e = exp_bytes.pop_front();
        if (ok && i < cur.size() && cur[i] !== e) begin ok = 0; ma = cur[i]; me = e; end
      end
      chk(ok, t, "SPI frame byte or length", ma, me);
    end
  end

  // every clock: CS high forces SCK low (R2)
  always @(negedge clk) if (rst_n && spi_cs_n)
    chk(!spi_sck, "R2", "SCK while CS high", spi_sck, 0);

  task automatic commit(input string tag);
    exp_len.push_back(stage.size()); exp_tag.push_back(tag);
    foreach (stage[i]) exp_bytes.push_back(stage[i]);
    stage.delete();
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    int n;
    n = 0;
    do begin @(negedge clk); rd(CTRL, v); n++; end while (v[5] && n < 20000);
    repeat (3) @(negedge clk);
    chk(exp_len.size() == 0, cur_tag, "expected frames not seen", exp_len.size(), 0);
  endtask

  task automatic go(input logic [3:0] cyc, input logic [5:0] cnt);
    wr(CTRL, 32'h0001_0007 | (32'(cyc) << 17) | (32'(cnt) << 24));
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    if (!finished) begin
      finished = 1; checks++; fails++;
      $display("FAIL R8 watchdog expired actual=busy expected=idle");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rd(CTRL, v); chk(v == 0, "R1", "control after reset", v, 0);
    rd(ERS, v);  chk(v == 0, "R1", "erase reg after reset", v, 0);
    chk(spi_cs_n === 1'b1 && spi_sck === 1'b0, "R1", "cs/sck after reset", {spi_cs_n, spi_sck}, 2'b10);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 read 8 bytes
    cur_tag = "R2";
    wr(FADR, 32'h0000_1234);
    stage = '{8'h03, 8'h00, 8'h12, 8'h34};
    for (int i = 0; i < 8; i++) stage.push_back(8'h00);
    commit("R2");
    go(4'd0, 6'd7);
    rd(CTRL, v); chk(v[5] == 1'b1, "R8", "busy after go", v[5], 1);
    wait_idle();
    rd(CTRL, v); chk((v & 32'h3F1F_0027) == 32'h0700_0001, "R8", "done, go clear, fields", v, 32'h0700_0001);
    for (int w = 0; w < 2; w++) begin
      logic [31:0] e;
      for (int b = 0; b < 4; b++) e[8*b +: 8] = fdat(24'h001234 + 24'(4*w + b));
      rd(BUF0 + 8'(4*w), v); chk(v == e, "R2", "read data in buffer", v, e);
    end

    // R3 write 5 bytes
    cur_tag = "R3";
    wr(BUF0, 32'h4433_2211); wr(BUF0 + 4, 32'h0000_0055); wr(FADR, 32'h0000_2100);
    stage = '{8'h06}; commit("R3");
    stage = '{8'h02, 8'h00, 8'h21, 8'h00, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55}; commit("R3");
    go(4'd2, 6'd4); wait_idle();

    // R4 erases
    cur_tag = "R4";
    wr(ERS, 32'h00D8_2000); wr(FADR, 32'h0003_A000);
    stage = '{8'h06}; commit("R4");
    stage = '{8'h20, 8'h03, 8'hA0, 8'h00}; commit("R4");
    go(4'd3, 6'd0); wait_idle();
    wr(FADR, 32'h0005_0000);
    stage = '{8'h06}; commit("R4");
    stage = '{8'hD8, 8'h05, 8'h00, 8'h00}; commit("R4");
    go(4'd4, 6'd0); wait_idle();
    wr(ERS, 32'h00D8_0000);
    go(4'd3, 6'd0); wait_idle();
    rd(CTRL, v); chk((v & 7) == 5, "R4", "zero opcode gives access error", v & 7, 5);

    // R5 id / status
    cur_tag = "R5";
    stage = '{8'h9F, 8'h00, 8'h00, 8'h00}; commit("R5");
    go(4'd6, 6'd2); wait_idle();
    rd(BUF0, v); chk((v & 32'hFFFFFF) == 32'hC2C1C0, "R5", "id bytes", v & 32'hFFFFFF, 32'hC2C1C0);
    stage = '{8'h05, 8'h00}; commit("R5");
    go(4'd8, 6'd0); wait_idle();
    rd(BUF0, v); chk(v[7:0] == 8'h5A, "R5", "status byte", v[7:0], 8'h5A);
    wr(BUF0, 32'h0000_BEEF);
    stage = '{8'h06}; commit("R5");
    stage = '{8'h01, 8'hEF, 8'hBE}; commit("R5");
    go(4'd7, 6'd1); wait_idle();

    // R6 boundary
    cur_tag = "R6";
    wr(FADR, 32'h0000_0FF0);
    stage = '{8'h03, 8'h00, 8'h0F, 8'hF0};
    for (int i = 0; i < 16; i++) stage.push_back(8'h00);
    commit("R6");
    go(4'd0, 6'd15); wait_idle();
    rd(CTRL, v); chk((v & 7) == 1, "R6", "read ending on boundary", v & 7, 1);
    rd(BUF0 + 12, v);
    begin
      logic [31:0] e;
      for (int b = 0; b < 4; b++) e[8*b +: 8] = fdat(24'h000FFC + 24'(b));
      chk(v == e, "R6", "last word before boundary", v, e);
    end
    go(4'd0, 6'd16); wait_idle();
    rd(CTRL, v); chk((v & 7) == 3, "R6", "crossing read refused", v & 7, 3);
    wr(FADR, 32'h0000_0FFF);
    go(4'd2, 6'd1); wait_idle();
    rd(CTRL, v); chk((v & 7) == 3, "R6", "crossing write refused", v & 7, 3);

    // R7 unsupported type
    cur_tag = "R7";
    go(4'd5, 6'd0); wait_idle();
    rd(CTRL, v); chk((v & 7) == 3, "R7", "type 5 refused", v & 7, 3);

    // R9 write-1-to-clear and collision
    cur_tag = "R9";
    wr(CTRL, 32'h0000_0002); rd(CTRL, v); chk((v & 7) == 1, "R9", "clear cycle error only", v & 7, 1);
    wr(CTRL, 32'h0000_0001); rd(CTRL, v); chk((v & 7) == 0, "R9", "clear done", v & 7, 0);
    go(4'd15, 6'd0);
    rd(CTRL, v); chk((v & 7) == 3, "R9", "set wins over clear (first)", v & 7, 3);
    go(4'd15, 6'd0);
    rd(CTRL, v); chk((v & 7) == 3, "R9", "set wins over clear (repeat)", v & 7, 3);

    // R10 go and buffer write while busy
    cur_tag = "R10";
    wr(BUF0 + 60, 32'h1234_5678); wr(FADR, 32'h0000_0100);
    stage = '{8'h03, 8'h00, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}; commit("R10");
    go(4'd0, 6'd3);
    repeat (10) @(negedge clk);
    wr(CTRL, 32'h0001_0000 | (32'd5 << 17));
    wr(BUF0 + 60, 32'hDEAD_BEEF);
    wait_idle();
    rd(CTRL, v); chk((v & 32'h001E_0007) == 32'h1, "R10", "go while busy ignored", v & 32'h001E_0007, 1);
    rd(BUF0 + 60, v); chk(v == 32'h1234_5678, "R10", "buffer write while busy", v, 32'h1234_5678);

    // R11 lock
    cur_tag = "R11";
    rd(CTRL, v); chk(v[15] == 1'b0, "R11", "lock before set", v[15], 0);
    wr(CTRL, 32'h0000_8000); rd(CTRL, v); chk(v[15] == 1'b1, "R11", "lock set", v[15], 1);
    wr(ERS, 32'h1122_3344); rd(ERS, v); chk(v == 32'h00D8_0000, "R11", "erase reg frozen", v, 32'h00D8_0000);
    wr(CTRL, 32'h0000_0000); rd(CTRL, v); chk(v[15] == 1'b1, "R11", "lock sticky", v[15], 1);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule